// File: doc/BRIEF.md
# Accumulator-to-Activation Requantizer

This block turns one wide signed accumulator value per cycle into a narrow signed activation for the next network layer. It first adds a signed per-layer offset to the accumulator at full precision, then multiplies the sum by a signed per-layer scale. It then divides by a power of two given by a programmable shift, rounding ties away from zero. An optional rectifier can be applied before the result is saturated to the activation width. The scale and shift together act as a fixed-point multiplier.

All configuration inputs are sampled in the same cycle as the data they apply to, so the layer settings may change between any two values. A result leaves one register stage after its input, flagged by an output valid. The output holds its last value while no input is presented.

Top module: `requant_relu8`

## Requirements
- R1: `res_vld` equals `acc_vld` of the previous cycle. While `rst` is high and in the first cycle after it, `res_vld` and `res_act` are 0.
- R2: Offset and accumulator are summed with one extra bit of width, so the sum never wraps. For example, 2147483647 + 1 scaled by 1 and shifted by 25 gives 64.
- R3: The sum times the scale is kept at its full width before the shift. For example, 2^20 times 2^20 shifted by 34 gives 64.
- R4: With a shift of 0, the product passes to the clamp unrounded.
- R5: With a shift n > 0, the product is divided by 2^n and ties round away from zero: 5 >> 1 gives 3, -5 >> 1 gives -3, -3 >> 1 gives -2, 7 >> 2 gives 2.
- R6: With `relu_en` = 1, negative values give 0 and the result saturates to 0..127.
- R7: With `relu_en` = 0, the result saturates to -128..127 and is written as two's complement in `res_act`.
- R8: While `acc_vld` is 0, `res_act` keeps its last value, whatever the other inputs do.
- R9: Scale, offset, shift and `relu_en` are taken from the cycle in which `acc_vld` is high, so back-to-back values may each use different settings.
- R10: With a non-negative scale and a non-negative sum, the result is never negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Accumulator value present this cycle |
| acc_val | input | 32 | Signed accumulator value |
| lyr_offset | input | 32 | Signed offset added before scaling |
| lyr_scale | input | 32 | Signed scale multiplier |
| lyr_shift | input | 6 | Right-shift amount, 0..63 |
| relu_en | input | 1 | Clamp negative values to zero |
| res_vld | output | 1 | Activation present this cycle |
| res_act | output | 8 | Signed activation |

## Verification
The function is tried with hand-picked values and with random ones. Small exact values with a unit scale check the shift-0 path. Values that land exactly on a half check the tie direction for both signs, which tells a design that rounds away from zero from one that truncates or rounds up. Values near the 32-bit limit and large scale products show whether the sum and the product keep their full width. Values beyond ±127 are run with the rectifier on and off to check each saturation window. Back-to-back values with changing settings, and idle cycles with changing inputs, check that the settings are sampled with each value and that the output holds between values.

// File: rtl/requant_pkg.sv
package requant_pkg;
  localparam int ACC_W_DEF   = 32;
  localparam int SCALE_W_DEF = 32;
  localparam int SHIFT_W_DEF = 6;
  localparam int OUT_W_DEF   = 8;

  // width of accumulator + offset without wrap
  function automatic int sum_width(input int acc_w);
    return acc_w + 1;
  endfunction

  // width of full product plus one rounding guard bit
  function automatic int rnd_width(input int acc_w, input int scale_w);
    return sum_width(acc_w) + scale_w + 1;
  endfunction
endpackage

// File: rtl/requant_mul.sv
module requant_mul
  import requant_pkg::*;
#(
  parameter int ACC_W   = ACC_W_DEF,
  parameter int SCALE_W = SCALE_W_DEF,
  localparam int SUM_W  = sum_width(ACC_W),
  localparam int PROD_W = SUM_W + SCALE_W
) (
  input  logic signed [ACC_W-1:0]   acc_i,
  input  logic signed [ACC_W-1:0]   offset_i,
  input  logic signed [SCALE_W-1:0] scale_i,
  output logic signed [PROD_W-1:0]  prod_o
);
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum    = SUM_W'(acc_i) + SUM_W'(offset_i);
    prod_o = PROD_W'(sum) * PROD_W'(scale_i);
  end
endmodule

// File: rtl/requant_round.sv
module requant_round
  import requant_pkg::*;
#(
  parameter int IN_W    = 65,
  parameter int SHIFT_W = SHIFT_W_DEF,
  localparam int RND_W  = IN_W + 1
) (
  input  logic signed [IN_W-1:0]    val_i,
  input  logic        [SHIFT_W-1:0] shift_i,
  output logic signed [RND_W-1:0]   val_o
);
  logic signed [RND_W-1:0] ext;
  logic signed [RND_W-1:0] half;
  logic signed [RND_W-1:0] adj;

  always_comb begin
    ext  = RND_W'(val_i);
    half = '0;
    if (shift_i != '0) begin
      half = {{(RND_W-1){1'b0}}, 1'b1} << (shift_i - SHIFT_W'(1));
    end
    adj = ext + half;
    // ties on negative values go further from zero
    if (shift_i != '0 && ext[RND_W-1]) begin
      adj = adj - RND_W'(1);
    end
    val_o = adj >>> shift_i;
  end
endmodule

// File: rtl/requant_clamp.sv
module requant_clamp #(
  parameter int IN_W  = 66,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0]  val_i,
  input  logic                    relu_i,
  output logic signed [OUT_W-1:0] act_o
);
  localparam logic signed [IN_W-1:0] TOP = IN_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [IN_W-1:0] BOT = -IN_W'(64'sd1 <<< (OUT_W-1));

  logic signed [IN_W-1:0] floor_v;

  always_comb begin
    floor_v = relu_i ? '0 : BOT;
    if (val_i > TOP) begin
      act_o = OUT_W'(TOP);
    end else if (val_i < floor_v) begin
      act_o = OUT_W'(floor_v);
    end else begin
      act_o = OUT_W'(val_i);
    end
  end
endmodule

// File: rtl/requant_relu8.sv
module requant_relu8
  import requant_pkg::*;
#(
  parameter int ACC_W   = ACC_W_DEF,
  parameter int SCALE_W = SCALE_W_DEF,
  parameter int SHIFT_W = SHIFT_W_DEF,
  parameter int OUT_W   = OUT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_vld,
  input  logic [ACC_W-1:0]   acc_val,
  input  logic [ACC_W-1:0]   lyr_offset,
  input  logic [SCALE_W-1:0] lyr_scale,
  input  logic [SHIFT_W-1:0] lyr_shift,
  input  logic               relu_en,
  output logic               res_vld,
  output logic [OUT_W-1:0]   res_act
);
  localparam int PROD_W = sum_width(ACC_W) + SCALE_W;
  localparam int RND_W  = rnd_width(ACC_W, SCALE_W);

  logic signed [PROD_W-1:0] prod;
  logic signed [RND_W-1:0]  rounded;
  logic signed [OUT_W-1:0]  act_nxt;

  requant_mul #(.ACC_W(ACC_W), .SCALE_W(SCALE_W)) mul_i (
    .acc_i    ($signed(acc_val)),
    .offset_i ($signed(lyr_offset)),
    .scale_i  ($signed(lyr_scale)),
    .prod_o   (prod)
  );

  requant_round #(.IN_W(PROD_W), .SHIFT_W(SHIFT_W)) rnd_i (
    .val_i   (prod),
    .shift_i (lyr_shift),
    .val_o   (rounded)
  );

  requant_clamp #(.IN_W(RND_W), .OUT_W(OUT_W)) clamp_i (
    .val_i  (rounded),
    .relu_i (relu_en),
    .act_o  (act_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res_act <= '0;
    end else begin
      res_vld <= acc_vld;
      if (acc_vld) begin
        res_act <= act_nxt;
      end
    end
  end
endmodule

// File: rtl/requant_relu8_chk.sv
module requant_relu8_chk #(
  parameter int ACC_W   = 32,
  parameter int SCALE_W = 32,
  parameter int SHIFT_W = 6,
  parameter int OUT_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_vld,
  input logic [ACC_W-1:0]   acc_val,
  input logic [ACC_W-1:0]   lyr_offset,
  input logic [SCALE_W-1:0] lyr_scale,
  input logic               relu_en,
  input logic               res_vld,
  input logic [OUT_W-1:0]   res_act
);
  logic [ACC_W:0] sum_chk;
  assign sum_chk = {acc_val[ACC_W-1], acc_val} + {lyr_offset[ACC_W-1], lyr_offset};

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> res_vld == $past(acc_vld)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(acc_vld)) |-> $stable(res_act)); // R8

  AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && relu_en) |=> !res_act[OUT_W-1]); // R6

  AST_ZERO_SUM: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && sum_chk == '0) |=> res_act == '0); // R2

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && !lyr_scale[SCALE_W-1] && !sum_chk[ACC_W]) |=> !res_act[OUT_W-1]); // R10
endmodule

bind requant_relu8 requant_relu8_chk #(
  .ACC_W(ACC_W), .SCALE_W(SCALE_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)
) chk_i (
  .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_val(acc_val),
  .lyr_offset(lyr_offset), .lyr_scale(lyr_scale), .relu_en(relu_en),
  .res_vld(res_vld), .res_act(res_act)
);

// File: tb/requant_relu8_tb_top.sv
module requant_relu8_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_vld;
  logic [31:0] acc_val;
  logic [31:0] lyr_offset;
  logic [31:0] lyr_scale;
  logic [5:0]  lyr_shift;
  logic        relu_en;
  logic        res_vld;
  logic [7:0]  res_act;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  requant_relu8 dut_i (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_val(acc_val),
    .lyr_offset(lyr_offset), .lyr_scale(lyr_scale), .lyr_shift(lyr_shift),
    .relu_en(relu_en), .res_vld(res_vld), .res_act(res_act)
  );

  // independent reference: magnitude rounding in 128-bit arithmetic
  function automatic logic [7:0] model(input logic [31:0] a, input logic [31:0] b,
                                       input logic [31:0] s, input logic [5:0] sh,
                                       input logic relu);
    logic signed [127:0] sum, p, mag, q, lo;
    sum = 128'($signed(a)) + 128'($signed(b));
    p   = sum * 128'($signed(s));
    mag = (p < 0) ? -p : p;
    if (sh != 0) mag = (mag + (128'sd1 <<< (sh - 1))) >>> sh;
    q   = (p < 0) ? -mag : mag;
    lo  = relu ? 128'sd0 : -128'sd128;
    if (q > 127) q = 127;
    if (q < lo) q = lo;
    return q[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic drive(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] s, input logic [5:0] sh, input logic relu);
    @(negedge clk);
    acc_vld = 1'b1; acc_val = a; lyr_offset = b; lyr_scale = s;
    lyr_shift = sh; relu_en = relu;
    exp_q.push_back(model(a, b, s, sh, relu));
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_vld = 1'b0;
    end
  endtask

  // monitor: compare each valid result against the queue
  always @(negedge clk) begin
    if (!rst && res_vld) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R1 actual=unexpected result expected=none");
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, res_act, e);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; acc_vld = 1'b1; acc_val = 32'd50; lyr_offset = '0;
    lyr_scale = 32'd1; lyr_shift = '0; relu_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset vld", {7'd0, res_vld}, 8'd0);
    check("R1 reset act", res_act, 8'd0);
    acc_vld = 1'b0; rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset vld", {7'd0, res_vld}, 8'd0);

    drive("R4 pass", 32'd100, 32'd0, 32'd1, 6'd0, 1'b0);
    drive("R4 neg pass", -32'sd77, 32'd0, 32'd1, 6'd0, 1'b0);
    drive("R7 hi sat", 32'd200, 32'd0, 32'd1, 6'd0, 1'b0);
    drive("R7 lo sat", -32'sd300, 32'd0, 32'd1, 6'd0, 1'b0);
    drive("R6 relu neg", -32'sd5, 32'd0, 32'd1, 6'd0, 1'b1);
    drive("R6 relu hi", 32'd300, 32'd0, 32'd1, 6'd0, 1'b1);
    drive("R6 relu pass", 32'd42, 32'd0, 32'd1, 6'd0, 1'b1);
    drive("R5 +2.5", 32'd5, 32'd0, 32'd1, 6'd1, 1'b0);
    drive("R5 -2.5", -32'sd5, 32'd0, 32'd1, 6'd1, 1'b0);
    drive("R5 -1.5", -32'sd3, 32'd0, 32'd1, 6'd1, 1'b0);
    drive("R5 1.75", 32'd7, 32'd0, 32'd1, 6'd2, 1'b0);
    drive("R5 -1.5b", -32'sd6, 32'd0, 32'd1, 6'd2, 1'b0);
    drive("R5 -1.25", -32'sd5, 32'd0, 32'd1, 6'd2, 1'b0);
    drive("R2 no wrap", 32'h7FFF_FFFF, 32'd1, 32'd1, 6'd25, 1'b0);
    drive("R2 neg no wrap", 32'h8000_0000, 32'hFFFF_FFFF, 32'd1, 6'd26, 1'b0);
    drive("R3 wide prod", 32'h0010_0000, 32'd0, 32'h0010_0000, 6'd34, 1'b0);
    drive("R3 neg scale", 32'd1000, 32'd0, -32'sd3, 6'd6, 1'b0);
    drive("R10 offset", 32'd10, 32'd20, 32'd3, 6'd1, 1'b0);
    // R9: settings change on every value with no gap
    drive("R9 a", -32'sd40, 32'd0, 32'd1, 6'd0, 1'b0);
    drive("R9 b", -32'sd40, 32'd0, 32'd1, 6'd0, 1'b1);
    drive("R9 c", -32'sd40, 32'd100, 32'd2, 6'd2, 1'b0);
    idle(2);

    // R8: idle with changing inputs, output must hold at 30
    drive("R8 seed", 32'd30, 32'd0, 32'd1, 6'd0, 1'b0);
    @(negedge clk);
    acc_vld = 1'b0; acc_val = 32'd99; relu_en = 1'b1; lyr_scale = -32'sd1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 hold", res_act, 8'd30);
      check("R8 no vld", {7'd0, res_vld}, 8'd0);
      acc_val = acc_val + 32'd7;
    end

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b, s;
      a = $urandom; b = $urandom >> ($urandom % 32);
      s = $urandom >> ($urandom % 32);
      if ($urandom % 2) s = -s;
      drive("R5 R7 random", a, b, s, 6'($urandom % 64), 1'($urandom % 2));
      if (i % 17 == 0) idle(1);
    end
    idle(3);
    check("R1 queue drained", 8'(exp_q.size()), 8'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule